// File: doc/BRIEF.md
# Bus-Programmed Eight-Pin Port Controller

This block is a two-wire serial slave that turns bus transactions into register state for an eight-pin general-purpose port. It sits behind an SCL/SDA pair that has already been synchronized to the block clock, and it pulls SDA low through an open-drain output enable. A 7-bit device address is matched, with its lowest bit taken from a strap input. The first byte after an accepted write address is stored in a write-only pointer. Further bytes in the same transfer are written to the register the pointer selects. After a repeated START with the read bit set, the selected register is returned one byte after another until the master declines to acknowledge.

The register file holds pin direction, output levels, input polarity, per-pin drive strength, input latch enables, pull enables and pull directions, the interrupt mask and the output-stage mode. It also exposes an interrupt status value that a separate interrupt engine provides. All of this state is driven straight to the pad controls. When the input register is read over the bus, a one-clock pulse tells the interrupt engine to clear, and it is timed to the acknowledge slot of each such byte.

Top module: `gpio_xpdr_i2c`

## Requirements
- R1: The device answers only the address whose upper six bits are 010000 and whose lowest bit equals `strap_i`, acknowledging by pulling SDA in the ninth clock. Any other address gets no acknowledge, and the rest of that transfer changes nothing.
- R2: The byte after an accepted write address becomes the pointer. Every further byte of that transfer is written to the one pointed register, with no increment, so the last byte wins.
- R3: Pointers 01h (output levels), 02h (polarity) and 03h (direction, 1 = input) read back the value written. Reading 01h returns the stored levels and not the pin levels.
- R4: Reading pointer 00h returns `pin_i` XOR polarity, whatever the pin direction. Writes to 00h change nothing.
- R5: The extended pointers are writable and read back their values: 40h holds drive bits 7:0 and 41h holds bits 15:8, with pin n at bits 2n+1:2n. The others are 42h latch enable, 43h pull enable, 44h pull direction (1 = up) and 45h interrupt mask (1 = masked).
- R6: Pointer 46h returns `irq_status_i` and ignores writes. Any pointer outside the map reads 00h and ignores writes.
- R7: After `rst_n` is low, these are the defaults: direction FFh, output FFh, polarity 00h, drive FFFFh, latch 00h, pull enable 00h, pull direction FFh, mask FFh, output-stage mode 00h. SDA is released.
- R8: `pad_oe_o` is the bitwise inverse of the direction register. `pad_out_o`, `pad_drive_o`, `pad_pull_up_o`, `latch_en_o` and `irq_mask_o` follow their registers.
- R9: Bit 0 of pointer 4Fh selects open-drain mode (1) on `pad_od_o`, and while it is set `pad_pull_en_o` is forced to 00h. The register reads back as 0000000b, with b the stored bit.
- R10: A read with no command phase uses the last stored pointer. A read returns the selected register for every byte the master acknowledges, and SDA is released after a not-acknowledge.
- R11: `int_clr_o` pulses for one clock after the SCL rising edge in the acknowledge slot of each byte read from pointer 00h, and never for other pointers.
- R12: A STOP at any bit aborts the transfer and discards a partial byte. A repeated START restarts the address phase.
- R13: `sda_oe_o` is asserted only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 1 | Lowest device address bit |
| pin_i | input | 8 | Pad input levels |
| irq_status_i | input | 8 | Interrupt source bits from the interrupt engine |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_out_o | output | 8 | Per-pin output level |
| pad_drive_o | output | 16 | Two drive-strength bits per pin |
| pad_od_o | output | 1 | Open-drain output stage selected |
| pad_pull_en_o | output | 8 | Per-pin pull resistor enable |
| pad_pull_up_o | output | 8 | Per-pin pull direction, 1 = up |
| latch_en_o | output | 8 | Per-pin input latch enable |
| irq_mask_o | output | 8 | Per-pin interrupt mask |
| int_clr_o | output | 1 | One-clock interrupt clear pulse |

## Verification
SCL and SDA edges are found one clock after they arrive. SDA acknowledge and data drive therefore change one clock after a falling SCL edge. A register write is visible on the pad outputs one clock after the falling SCL edge that ends the eighth data bit. The clear pulse appears one clock after the SCL rising edge of the acknowledge slot. The bench holds every SCL phase for four clocks and samples SDA and pad outputs on falling clock edges. Each sample therefore falls at least two clocks after the result is due and well before the next bus edge. The clear pulses are counted by a monitor sampling just after each rising edge.

// File: rtl/gpio_xpdr_i2c.sv
module gpio_xpdr_i2c #(
  parameter logic [5:0] DEV_ADDR_HI = 6'b010000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic        strap_i,
  input  logic [7:0]  pin_i,
  input  logic [7:0]  irq_status_i,
  output logic [7:0]  pad_oe_o,
  output logic [7:0]  pad_out_o,
  output logic [15:0] pad_drive_o,
  output logic        pad_od_o,
  output logic [7:0]  pad_pull_en_o,
  output logic [7:0]  pad_pull_up_o,
  output logic [7:0]  latch_en_o,
  output logic [7:0]  irq_mask_o,
  output logic        int_clr_o
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} kind_t;

  st_t         st;
  kind_t       kind;
  logic        scl_d, sda_d;
  logic [3:0]  bitcnt;
  logic [7:0]  sh, tx, ptr;
  logic        rw, nack, sda_oe, int_clr;

  logic [7:0]  r_dir, r_out, r_pol, r_latch, r_pen, r_psel, r_mask;
  logic [15:0] r_drv;
  logic        r_od;
  logic [7:0]  rd_val;

  wire scl_rise = scl_i & ~scl_d;
  wire scl_fall = ~scl_i & scl_d;
  wire start_c  = scl_i & scl_d & sda_d & ~sda_i;
  wire stop_c   = scl_i & scl_d & ~sda_d & sda_i;
  wire byte_end = (st == S_RX) && scl_fall && (bitcnt == 4'd8) && !start_c && !stop_c;
  wire wr_fire  = byte_end && (kind == K_DATA);

  always_comb begin
    case (ptr)
      8'h00:   rd_val = pin_i ^ r_pol;
      8'h01:   rd_val = r_out;
      8'h02:   rd_val = r_pol;
      8'h03:   rd_val = r_dir;
      8'h40:   rd_val = r_drv[7:0];
      8'h41:   rd_val = r_drv[15:8];
      8'h42:   rd_val = r_latch;
      8'h43:   rd_val = r_pen;
      8'h44:   rd_val = r_psel;
      8'h45:   rd_val = r_mask;
      8'h46:   rd_val = irq_status_i;
      8'h4F:   rd_val = {7'b0, r_od};
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      st      <= S_IDLE;
      kind    <= K_ADDR;
      bitcnt  <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      int_clr <= 1'b0;
    end else begin
      scl_d   <= scl_i;
      sda_d   <= sda_i;
      int_clr <= 1'b0;
      if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        st     <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= {sh[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_end) begin
              case (kind)
                K_ADDR: begin
                  if (sh[7:1] == {DEV_ADDR_HI, strap_i}) begin
                    rw     <= sh[0];
                    st     <= S_RXACK;
                    sda_oe <= 1'b1;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                K_CMD: begin
                  ptr    <= sh;
                  st     <= S_RXACK;
                  sda_oe <= 1'b1;
                end
                default: begin
                  st     <= S_RXACK;
                  sda_oe <= 1'b1;
                end
              endcase
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (kind == K_ADDR && rw) begin
                tx     <= rd_val;
                sda_oe <= ~rd_val[7];
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_RX;
                kind   <= (kind == K_ADDR) ? K_CMD : K_DATA;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= S_TXACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              nack    <= sda_i;
              int_clr <= (ptr == 8'h00);
            end else if (scl_fall) begin
              if (nack) begin
                st <= S_IDLE;
              end else begin
                tx     <= rd_val;
                sda_oe <= ~rd_val[7];
                bitcnt <= '0;
                st     <= S_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_dir   <= 8'hFF;
      r_out   <= 8'hFF;
      r_pol   <= 8'h00;
      r_drv   <= 16'hFFFF;
      r_latch <= 8'h00;
      r_pen   <= 8'h00;
      r_psel  <= 8'hFF;
      r_mask  <= 8'hFF;
      r_od    <= 1'b0;
    end else if (wr_fire) begin
      case (ptr)
        8'h01:   r_out        <= sh;
        8'h02:   r_pol        <= sh;
        8'h03:   r_dir        <= sh;
        8'h40:   r_drv[7:0]   <= sh;
        8'h41:   r_drv[15:8]  <= sh;
        8'h42:   r_latch      <= sh;
        8'h43:   r_pen        <= sh;
        8'h44:   r_psel       <= sh;
        8'h45:   r_mask       <= sh;
        8'h4F:   r_od         <= sh[0];
        default: ;
      endcase
    end
  end

  assign sda_oe_o      = sda_oe;
  assign int_clr_o     = int_clr;
  assign pad_oe_o      = ~r_dir;
  assign pad_out_o     = r_out;
  assign pad_drive_o   = r_drv;
  assign pad_od_o      = r_od;
  assign pad_pull_en_o = r_od ? 8'h00 : r_pen;
  assign pad_pull_up_o = r_psel;
  assign latch_en_o    = r_latch;
  assign irq_mask_o    = r_mask;

endmodule

// File: rtl/gpio_xpdr_i2c_chk.sv
module gpio_xpdr_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       int_clr_o,
  input logic [7:0] pad_oe_o
);

  AST_SDA_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i); // R13

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr_o |=> !int_clr_o); // R11

  AST_CLR_AFTER_SCL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr_o |-> ($past(scl_i) && !$past(scl_i, 2))); // R11

  AST_DIR_WRITE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_oe_o) |-> !$past(scl_i)); // R3

endmodule

bind gpio_xpdr_i2c gpio_xpdr_i2c_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .int_clr_o (int_clr_o),
  .pad_oe_o  (pad_oe_o)
);

// File: tb/gpio_xpdr_i2c_bench.sv
`timescale 1ns/1ps
module gpio_xpdr_i2c_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        strap = 1'b0;
  logic [7:0]  pin = 8'h00;
  logic [7:0]  irq_st = 8'h00;
  logic        sda_i;
  logic        sda_oe_o;
  logic [7:0]  pad_oe_o, pad_out_o, pad_pull_en_o, pad_pull_up_o, latch_en_o, irq_mask_o;
  logic [15:0] pad_drive_o;
  logic        pad_od_o, int_clr_o;

  int errs = 0;
  int checks = 0;
  int clr_cnt = 0;
  int viol = 0;
  logic oe_q = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  assign sda_i = sda_m & ~sda_oe_o;

  gpio_xpdr_i2c u_gpio_xpdr_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i), .sda_oe_o(sda_oe_o),
    .strap_i(strap), .pin_i(pin), .irq_status_i(irq_st),
    .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o), .pad_drive_o(pad_drive_o),
    .pad_od_o(pad_od_o), .pad_pull_en_o(pad_pull_en_o), .pad_pull_up_o(pad_pull_up_o),
    .latch_en_o(latch_en_o), .irq_mask_o(irq_mask_o), .int_clr_o(int_clr_o)
  );

  always @(posedge clk) begin
    #2;
    if (int_clr_o) clr_cnt++;
    if (sda_oe_o && !oe_q && scl_m) viol++;
    oe_q = sda_oe_o;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wr_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q();
  endtask

  task automatic rd_bit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_i; scl_m = 1'b0; q();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wr_bit(d[i]);
    rd_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic ack_m, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      d[i] = b;
    end
    wr_bit(~ack_m);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {6'b010000, strap, rd};
  endfunction

  task automatic reg_wr(input logic [7:0] p, input logic [7:0] d);
    logic a;
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(p, a); wr_byte(d, a); bus_stop();
  endtask

  task automatic reg_rd(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(p, a);
    bus_start(); wr_byte(dev(1'b1), a); rd_byte(1'b0, d); bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R7 pad_oe", pad_oe_o, 8'h00);
    chk("R7 pad_out", pad_out_o, 8'hFF);
    chk("R7 drive", pad_drive_o, 16'hFFFF);
    chk("R7 pull_en", pad_pull_en_o, 8'h00);
    chk("R7 pull_up", pad_pull_up_o, 8'hFF);
    chk("R7 latch", latch_en_o, 8'h00);
    chk("R7 mask", irq_mask_o, 8'hFF);
    chk("R7 od", pad_od_o, 1'b0);
    chk("R7 sda", sda_oe_o, 1'b0);
    reg_rd(8'h03, d); chk("R7 dir read", d, 8'hFF);
    reg_rd(8'h02, d); chk("R7 pol read", d, 8'h00);
  endtask

  task automatic t_addr();
    logic a;
    logic [7:0] d;
    strap = 1'b0;
    bus_start(); wr_byte(8'h42, a); bus_stop();
    chk("R1 wrong addr nack", a, 1'b0);
    bus_start(); wr_byte(8'h40, a); bus_stop();
    chk("R1 strap0 ack", a, 1'b1);
    strap = 1'b1;
    bus_start(); wr_byte(8'h40, a); wr_byte(8'h01, a); wr_byte(8'h00, a); bus_stop();
    chk("R1 strap1 rejects old addr", a, 1'b0);
    chk("R1 ignored transfer", pad_out_o, 8'hFF);
    bus_start(); wr_byte(8'h42, a); bus_stop();
    chk("R1 strap1 ack", a, 1'b1);
  endtask

  task automatic t_base();
    logic [7:0] d;
    pin = 8'h00;
    reg_wr(8'h01, 8'hA5);
    chk("R8 pad_out", pad_out_o, 8'hA5);
    reg_rd(8'h01, d); chk("R3 out read not pin", d, 8'hA5);
    reg_wr(8'h03, 8'h0F);
    chk("R8 pad_oe inverse", pad_oe_o, 8'hF0);
    reg_rd(8'h03, d); chk("R3 dir read", d, 8'h0F);
  endtask

  task automatic t_input();
    logic [7:0] d;
    pin = 8'h3C;
    reg_wr(8'h02, 8'h00);
    reg_rd(8'h00, d); chk("R4 input plain", d, 8'h3C);
    reg_wr(8'h02, 8'hFF);
    reg_rd(8'h00, d); chk("R4 input inverted", d, 8'hC3);
    reg_wr(8'h00, 8'h55);
    reg_rd(8'h00, d); chk("R4 write ignored", d, 8'hC3);
    reg_rd(8'h02, d); chk("R3 pol read", d, 8'hFF);
    reg_wr(8'h02, 8'h00);
  endtask

  task automatic t_multi();
    logic a;
    logic [7:0] d;
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h02, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a); bus_stop();
    reg_rd(8'h02, d); chk("R2 last byte same reg", d, 8'h33);
    reg_rd(8'h03, d); chk("R2 no increment", d, 8'h0F);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    reg_wr(8'h40, 8'h1B);
    reg_wr(8'h41, 8'hE4);
    chk("R5 drive pads", pad_drive_o, 16'hE41B);
    reg_rd(8'h41, d); chk("R5 drive hi read", d, 8'hE4);
    reg_wr(8'h42, 8'h5A); chk("R8 latch pad", latch_en_o, 8'h5A);
    reg_wr(8'h43, 8'hF0); chk("R5 pull_en pad", pad_pull_en_o, 8'hF0);
    reg_wr(8'h44, 8'h0F); chk("R8 pull_up pad", pad_pull_up_o, 8'h0F);
    reg_wr(8'h45, 8'h00); chk("R8 mask pad", irq_mask_o, 8'h00);
    reg_rd(8'h42, d); chk("R5 latch read", d, 8'h5A);
    reg_rd(8'h45, d); chk("R5 mask read", d, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    irq_st = 8'h96;
    reg_rd(8'h46, d); chk("R6 status read", d, 8'h96);
    reg_wr(8'h47, 8'h77);
    reg_rd(8'h47, d); chk("R6 unknown reads zero", d, 8'h00);
    reg_rd(8'h04, d); chk("R6 hole reads zero", d, 8'h00);
  endtask

  task automatic t_od();
    logic [7:0] d;
    reg_wr(8'h4F, 8'h01);
    chk("R9 od pad", pad_od_o, 1'b1);
    chk("R9 pulls off", pad_pull_en_o, 8'h00);
    reg_wr(8'h4F, 8'hFF);
    reg_rd(8'h4F, d); chk("R9 od read", d, 8'h01);
    reg_wr(8'h4F, 8'h00);
    chk("R9 pulls back", pad_pull_en_o, 8'hF0);
  endtask

  task automatic t_read_seq();
    logic a;
    logic [7:0] d0, d1, d2;
    reg_wr(8'h01, 8'h6D);
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h01, a);
    bus_start(); wr_byte(dev(1'b1), a);
    rd_byte(1'b1, d0); rd_byte(1'b1, d1); rd_byte(1'b0, d2);
    chk("R10 nack releases", sda_oe_o, 1'b0);
    bus_stop();
    chk("R10 burst byte0", d0, 8'h6D);
    chk("R10 burst byte2", d2, 8'h6D);
    reg_wr(8'h02, 8'h5C);
    bus_start(); wr_byte(dev(1'b1), a); rd_byte(1'b0, d0); bus_stop();
    chk("R10 stored pointer", d0, 8'h5C);
    reg_wr(8'h02, 8'h00);
  endtask

  task automatic t_clr();
    logic a;
    logic [7:0] d;
    int c0;
    c0 = clr_cnt;
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h00, a);
    bus_start(); wr_byte(dev(1'b1), a);
    rd_byte(1'b1, d); rd_byte(1'b0, d); bus_stop();
    chk("R11 two clears", clr_cnt - c0, 2);
    c0 = clr_cnt;
    reg_rd(8'h01, d);
    chk("R11 no clear other reg", clr_cnt - c0, 0);
  endtask

  task automatic t_stop();
    logic a;
    logic [7:0] d;
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h01, a);
    wr_bit(1'b0); wr_bit(1'b0); wr_bit(1'b0); wr_bit(1'b0);
    bus_stop();
    chk("R12 partial byte dropped", pad_out_o, 8'h6D);
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h01, a);
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h02, a); wr_byte(8'h99, a); bus_stop();
    reg_rd(8'h02, d); chk("R12 restart new pointer", d, 8'h99);
    chk("R12 old pointer untouched", pad_out_o, 8'h6D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_addr();
    t_base();
    t_input();
    t_multi();
    t_ext();
    t_status();
    t_od();
    t_read_seq();
    t_clr();
    t_stop();
    chk("R13 sda drive only with scl low", viol, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule